// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Sequencer

This block sits between a host write/read port and the command side of an SDRAM controller whose memory words carry SEC-DED check bits. A host write that covers every byte of a word goes to memory in the cycle it is accepted, together with freshly computed check bits. A write that covers only some bytes cannot just be masked, because the check bits depend on the whole word. The block therefore reads the word, waits out the CAS latency, corrects the returned data, merges in the new bytes and recomputes the check bits. After two idle cycles for bus turnaround it writes the full word back.

Read data coming back from memory is decoded on its way to the host, with no register in the path. Correction and error reporting are enabled per bank. A global generation switch decides whether writes carry valid check bits at all; it is used while software fills memory for the first time. Configuration writes made while a read-modify-write is running are held and applied once the block is idle again.

Top module: `rmw_seq`

## Requirements
- R1: A write with all byte enables set, accepted while idle, issues its write command and its acknowledge (`wr_ready_o`) in the same cycle, with no added cycle.
- R2: Read data from memory is presented to the host in the same cycle it arrives, and a single-bit error is corrected when checking is enabled for the bank in `mem_rbank_i`.
- R3: With check-bit generation on, a partial write issues a read command in its acceptance cycle. Its write command and acknowledge come exactly CAS latency + 4 cycles later, with all byte enables set. The CAS latency is `cas_lat_i`, legal values 2 and 3.
- R4: In the merged word, byte i (bits 8i+7..8i) comes from the host data when `wr_be_i[i]` is 1 and from the corrected read data otherwise.
- R5: For a bank whose checking is disabled, read data passes through unmodified and `rd_err_o` stays 0.
- R6: For an enabled bank, a double-bit error sets `rd_err_o` with the read data, and the data is not modified.
- R7: An uncorrectable error in the read phase of a read-modify-write does not stop the write; `wr_err_o` is 1 in the acknowledge cycle.
- R8: With check-bit generation off, writes carry all-zero check bits, and partial writes go out at once with their own byte enables and no read.
- R9: A configuration write made during a read-modify-write does not affect that sequence; it takes effect once the block is idle.
- R10: A write is acknowledged only in the cycle its final write command is issued. Host reads are refused while a write is pending or the block is busy.
- R11: After reset the block is idle, issues no command, has generation off and has checking disabled in every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 2 | CAS latency in cycles (2 or 3) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_gen_i | input | 1 | Check-bit generation enable to store |
| cfg_bank_i | input | BANKS | Per-bank check/correct enables to store |
| wr_valid_i | input | 1 | Host write request |
| wr_ready_o | output | 1 | Host write accepted and completed |
| wr_addr_i | input | ADDR_W | Write word address; top bits select the bank |
| wr_data_i | input | DATA_W | Write data |
| wr_be_i | input | DATA_W/8 | Write byte enables |
| wr_err_o | output | 1 | Uncorrectable error seen during read-modify-write |
| rd_valid_i | input | 1 | Host read request |
| rd_ready_o | output | 1 | Host read accepted |
| rd_addr_i | input | ADDR_W | Read word address |
| mem_rvalid_i | input | 1 | Read data valid from memory |
| mem_rdata_i | input | DATA_W | Read data from memory |
| mem_rchk_i | input | CHK_W | Check bits from memory |
| mem_rbank_i | input | log2(BANKS) | Bank of the returning read data |
| rd_data_o | output | DATA_W | Decoded read data to host |
| rd_dvalid_o | output | 1 | Read data valid to host |
| rd_err_o | output | 1 | Uncorrectable error on read data |
| cmd_valid_o | output | 1 | Memory command valid |
| cmd_write_o | output | 1 | Memory command is a write |
| cmd_addr_o | output | ADDR_W | Memory command address |
| cmd_data_o | output | DATA_W | Memory write data |
| cmd_chk_o | output | CHK_W | Memory write check bits |
| cmd_be_o | output | DATA_W/8 | Memory write byte enables |

## Verification
The bench builds the block with its default parameters: a 32-bit word with four byte lanes, seven check bits and four banks selected by the top two bits of a 16-bit address. Four lanes allow masks that keep alternate, high-only and single bytes. Four banks allow one run to hold an enabled bank next to a disabled one. Both legal CAS latencies are driven, so the partial-write penalty is seen at 6 and at 7 cycles. A memory model in the bench can flip chosen bits on the way back, which exercises correction, double-error reporting and a configuration change arriving mid-sequence.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MERGE,
    ST_TURN,
    ST_WRITE
  } rmw_state_e;

  // Hamming parity bits needed to cover dw data bits
  function automatic int par_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Codeword position (1-based) of data bit j: skips powers of two
  function automatic int code_pos(input int j);
    int p;
    int n;
    p = 0;
    n = -1;
    while (n < j) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

endpackage

// File: rtl/rmw_ecc.sv
module rmw_ecc #(
  parameter int DATA_W = 32,
  parameter int PAR_W  = rmw_pkg::par_bits(DATA_W),
  parameter int CHK_W  = PAR_W + 1
) (
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CHK_W-1:0]  enc_chk_o,
  input  logic              dec_en_i,
  input  logic [DATA_W-1:0] dec_data_i,
  input  logic [CHK_W-1:0]  dec_chk_i,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_dbl_o
);

  function automatic logic [PAR_W-1:0] hamm(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] p;
    p = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int k = 0; k < PAR_W; k++) begin
        if (((rmw_pkg::code_pos(j) >> k) & 1) == 1) p[k] = p[k] ^ d[j];
      end
    end
    return p;
  endfunction

  logic [PAR_W-1:0] enc_par;
  logic [PAR_W-1:0] syn;
  logic             ovr;

  always_comb begin
    enc_par   = hamm(enc_data_i);
    enc_chk_o = {(^enc_data_i) ^ (^enc_par), enc_par};
  end

  always_comb begin
    syn        = hamm(dec_data_i) ^ dec_chk_i[PAR_W-1:0];
    ovr        = (^dec_data_i) ^ (^dec_chk_i);
    dec_data_o = dec_data_i;
    if (dec_en_i && ovr) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (int'(syn) == rmw_pkg::code_pos(j)) dec_data_o[j] = ~dec_data_i[j];
      end
    end
    dec_dbl_o = dec_en_i && !ovr && (syn != '0);
  end

endmodule

// File: rtl/rmw_cfg.sv
module rmw_cfg #(
  parameter int BANKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             gen_i,
  input  logic [BANKS-1:0] bank_i,
  input  logic             apply_i,
  output logic             gen_o,
  output logic [BANKS-1:0] bank_o
);

  logic             pend_q;
  logic             pgen_q;
  logic [BANKS-1:0] pbank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pgen_q  <= 1'b0;
      pbank_q <= '0;
      gen_o   <= 1'b0;
      bank_o  <= '0;
    end else if (apply_i && (we_i || pend_q)) begin
      gen_o  <= we_i ? gen_i  : pgen_q;
      bank_o <= we_i ? bank_i : pbank_q;
      pend_q <= 1'b0;
    end else if (we_i) begin
      pend_q  <= 1'b1;
      pgen_q  <= gen_i;
      pbank_q <= bank_i;
    end
  end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int BANKS  = 4,
  parameter int CHK_W  = rmw_pkg::par_bits(DATA_W) + 1,
  parameter int BANK_W = $clog2(BANKS),
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cas_lat_i,
  input  logic              cfg_we_i,
  input  logic              cfg_gen_i,
  input  logic [BANKS-1:0]  cfg_bank_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  output logic              wr_err_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [CHK_W-1:0]  mem_rchk_i,
  input  logic [BANK_W-1:0] mem_rbank_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_dvalid_o,
  output logic              rd_err_o,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [CHK_W-1:0]  cmd_chk_o,
  output logic [BE_W-1:0]   cmd_be_o
);
  import rmw_pkg::*;

  rmw_state_e        state_q;
  logic [1:0]        cnt_q;
  logic              turn_q;
  logic              err_q;
  logic [DATA_W-1:0] fix_q;
  logic [DATA_W-1:0] merged_q;
  logic [DATA_W-1:0] merged_d;

  logic              gen_q;
  logic [BANKS-1:0]  bank_q;
  logic              busy;
  logic              idle;
  logic              rmw_start;
  logic              pass_wr;
  logic              capture;
  logic              in_write;
  logic [BANK_W-1:0] wr_bank;
  logic              dec_en;
  logic [DATA_W-1:0] dec_data;
  logic              dec_dbl;
  logic [CHK_W-1:0]  enc_chk;

  assign idle      = (state_q == ST_IDLE);
  assign busy      = !idle;
  assign in_write  = (state_q == ST_WRITE);
  assign capture   = (state_q == ST_WAIT) && (cnt_q == 2'd0);
  assign wr_bank   = wr_addr_i[ADDR_W-1 -: BANK_W];
  assign rmw_start = idle && wr_valid_i && !(&wr_be_i) && gen_q;
  assign pass_wr   = idle && wr_valid_i && !rmw_start;

  rmw_cfg #(.BANKS(BANKS)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .gen_i   (cfg_gen_i),
    .bank_i  (cfg_bank_i),
    .apply_i (idle && !rmw_start),
    .gen_o   (gen_q),
    .bank_o  (bank_q)
  );

  // one decoder serves host reads and the RMW read phase
  assign dec_en = capture ? bank_q[wr_bank] : bank_q[mem_rbank_i];

  rmw_ecc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_ecc (
    .enc_data_i (cmd_data_o),
    .enc_chk_o  (enc_chk),
    .dec_en_i   (dec_en),
    .dec_data_i (mem_rdata_i),
    .dec_chk_i  (mem_rchk_i),
    .dec_data_o (dec_data),
    .dec_dbl_o  (dec_dbl)
  );

  for (genvar b = 0; b < BE_W; b++) begin : g_merge
    assign merged_d[8*b +: 8] = wr_be_i[b] ? wr_data_i[8*b +: 8] : fix_q[8*b +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      turn_q   <= 1'b0;
      err_q    <= 1'b0;
      fix_q    <= '0;
      merged_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rmw_start) begin
          cnt_q   <= cas_lat_i - 2'd1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (cnt_q == 2'd0) begin
          fix_q   <= dec_data;
          err_q   <= dec_dbl;
          state_q <= ST_MERGE;
        end else begin
          cnt_q <= cnt_q - 2'd1;
        end
        ST_MERGE: begin
          merged_q <= merged_d;
          turn_q   <= 1'b0;
          state_q  <= ST_TURN;
        end
        ST_TURN: if (turn_q) state_q <= ST_WRITE;
                 else        turn_q  <= 1'b1;
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_ready_o  = pass_wr || in_write;
  assign wr_err_o    = in_write && err_q;
  assign rd_ready_o  = idle && !wr_valid_i;
  assign cmd_valid_o = (idle && (wr_valid_i || rd_valid_i)) || in_write;
  assign cmd_write_o = pass_wr || in_write;
  assign cmd_addr_o  = (idle && !wr_valid_i) ? rd_addr_i : wr_addr_i;
  assign cmd_data_o  = in_write ? merged_q : wr_data_i;
  assign cmd_chk_o   = gen_q ? enc_chk : '0;
  assign cmd_be_o    = pass_wr ? wr_be_i : '1;

  assign rd_dvalid_o = mem_rvalid_i && !capture;
  assign rd_data_o   = dec_data;
  assign rd_err_o    = rd_dvalid_o && dec_dbl;

endmodule

// File: rtl/rmw_seq_checker.sv
module rmw_seq_checker #(
  parameter int DATA_W = 32,
  parameter int BANKS  = 4,
  parameter int BE_W   = DATA_W / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cas_lat_i,
  input logic             wr_valid_i,
  input logic [BE_W-1:0]  wr_be_i,
  input logic             wr_ready_o,
  input logic             wr_err_o,
  input logic             rd_ready_o,
  input logic             cmd_valid_o,
  input logic             cmd_write_o,
  input logic [BE_W-1:0]  cmd_be_o,
  input logic             rd_dvalid_o,
  input logic             rd_err_o,
  input logic             busy,
  input logic             gen_q,
  input logic [BANKS-1:0] bank_q
);

  logic [3:0] lat_q;
  logic [1:0] cl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      cl_q  <= '0;
    end else if (!busy && wr_valid_i && !(&wr_be_i) && gen_q) begin
      lat_q <= 4'd1;
      cl_q  <= cas_lat_i;
    end else if (busy && lat_q != 4'hf) begin
      lat_q <= lat_q + 4'd1;
    end
  end

  assert_full_wr_now_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && wr_valid_i && (&wr_be_i)) |-> (wr_ready_o && cmd_valid_o && cmd_write_o));

  assert_rmw_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_ready_o) |-> (lat_q == ({2'b00, cl_q} + 4'd4)));

  assert_rmw_full_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_ready_o) |-> (&cmd_be_o));

  assert_wr_err_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> (wr_ready_o && busy));

  assert_rd_err_with_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_dvalid_o);

  assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> (!busy || ($stable(bank_q) && $stable(gen_q))));

  assert_ack_is_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> (cmd_valid_o && cmd_write_o));

  assert_no_read_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy || wr_valid_i) |-> !rd_ready_o);

endmodule

bind rmw_seq rmw_seq_checker #(
  .DATA_W (DATA_W),
  .BANKS  (BANKS)
) u_rmw_seq_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cas_lat_i   (cas_lat_i),
  .wr_valid_i  (wr_valid_i),
  .wr_be_i     (wr_be_i),
  .wr_ready_o  (wr_ready_o),
  .wr_err_o    (wr_err_o),
  .rd_ready_o  (rd_ready_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_write_o (cmd_write_o),
  .cmd_be_o    (cmd_be_o),
  .rd_dvalid_o (rd_dvalid_o),
  .rd_err_o    (rd_err_o),
  .busy        (busy),
  .gen_q       (gen_q),
  .bank_q      (bank_q)
);

// File: tb/rmw_seq_bench.sv
`timescale 1ns/1ps
module rmw_seq_bench;

  localparam int DW = 32;
  localparam int AW = 16;
  localparam int NB = 4;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cl = 2'd2;
  logic          cfg_we = 1'b0, cfg_gen = 1'b0;
  logic [NB-1:0] cfg_bank = '0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;

  logic          wr_ready, wr_err, rd_ready, rd_dvalid, rd_err;
  logic          mem_rvalid;
  logic [DW-1:0] mem_rdata, rd_data, cmd_data;
  logic [CW-1:0] mem_rchk, cmd_chk;
  logic [1:0]    mem_rbank;
  logic          cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [3:0]    cmd_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] inj = '0;

  always #2.5 clk = ~clk;

  rmw_seq u_rmw_seq (
    .clk_i(clk), .rst_ni(rst_n), .cas_lat_i(cl),
    .cfg_we_i(cfg_we), .cfg_gen_i(cfg_gen), .cfg_bank_i(cfg_bank),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .wr_err_o(wr_err),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_addr_i(rd_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_rchk_i(mem_rchk),
    .mem_rbank_i(mem_rbank), .rd_data_o(rd_data), .rd_dvalid_o(rd_dvalid),
    .rd_err_o(rd_err), .cmd_valid_o(cmd_valid), .cmd_write_o(cmd_write),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .cmd_chk_o(cmd_chk),
    .cmd_be_o(cmd_be)
  );

  // memory model: 16 words, read data returns cl cycles after the command
  logic [DW-1:0] mem_d [16];
  logic [CW-1:0] mem_c [16];
  logic          pv [4];
  logic [DW-1:0] pd [4];
  logic [CW-1:0] pc [4];
  logic [1:0]    pb [4];

  initial begin
    for (int i = 0; i < 16; i++) begin mem_d[i] = '0; mem_c[i] = '0; end
    for (int i = 0; i < 4; i++) begin pv[i] = 0; pd[i] = '0; pc[i] = '0; pb[i] = '0; end
  end

  always @(posedge clk) begin
    for (int i = 3; i > 0; i--) begin
      pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; pc[i] <= pc[i-1]; pb[i] <= pb[i-1];
    end
    pv[0] <= cmd_valid && !cmd_write;
    pd[0] <= mem_d[cmd_addr[3:0]] ^ inj;
    pc[0] <= mem_c[cmd_addr[3:0]];
    pb[0] <= cmd_addr[AW-1 -: 2];
    if (cmd_valid && cmd_write) begin
      for (int b = 0; b < 4; b++)
        if (cmd_be[b]) mem_d[cmd_addr[3:0]][8*b +: 8] <= cmd_data[8*b +: 8];
      mem_c[cmd_addr[3:0]] <= cmd_chk;
    end
  end

  assign mem_rvalid = pv[cl-2'd1];
  assign mem_rdata  = pd[cl-2'd1];
  assign mem_rchk   = pc[cl-2'd1];
  assign mem_rbank  = pb[cl-2'd1];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected host read results
  logic [DW:0] exp_q [$];
  string       tag_q [$];

  always @(negedge clk) begin
    if (rst_n && rd_dvalid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected read data", {31'd0, rd_err, rd_data}, 64'd0);
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rd_err, rd_data} == e, t, "read data/err", {31'd0, rd_err, rd_data}, {31'd0, e});
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [3:0] be, input int exp_lat,
                          input logic exp_err, input string req);
    int lat;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    #1;
    check(!rd_ready, "R10", "read accepted during write", {63'd0, rd_ready}, 64'd0);
    lat = 0;
    while (!wr_ready && lat < 40) begin
      @(negedge clk); #1; lat++;
    end
    check(lat == exp_lat, req, "write latency", 64'(lat), 64'(exp_lat));
    check(wr_err == exp_err, req, "write error flag", {63'd0, wr_err}, {63'd0, exp_err});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic e, input string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    #1;
    check(rd_ready, req, "read not accepted", {63'd0, rd_ready}, 64'd1);
    exp_q.push_back({e, d});
    tag_q.push_back(req);
    @(negedge clk);
    rd_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_cfg(input logic g, input logic [NB-1:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_gen = g; cfg_bank = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  localparam logic [AW-1:0] A0 = 16'h0001; // bank 0
  localparam logic [AW-1:0] A1 = 16'h4002; // bank 1
  localparam logic [AW-1:0] A2 = 16'h8003; // bank 2

  initial begin
    repeat (3) @(negedge clk);
    check(!cmd_valid && !wr_ready, "R11", "idle in reset", {62'd0, cmd_valid, wr_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid && rd_ready, "R11", "idle after reset", {62'd0, cmd_valid, rd_ready}, 64'd1);

    // generation off after reset: no RMW, zero check bits
    do_write(A0, 32'h11223344, 4'b1111, 0, 1'b0, "R1");
    do_write(A1, 32'hAABBCCDD, 4'b0011, 0, 1'b0, "R8");
    check(mem_c[2] == '0, "R8", "check bits with gen off", 64'(mem_c[2]), 64'd0);
    do_read(A1, 32'h0000CCDD, 1'b0, "R8");

    set_cfg(1'b1, 4'b0011);
    do_write(A0, 32'h11223344, 4'b1111, 0, 1'b0, "R1");
    do_write(A1, 32'h55667788, 4'b1111, 0, 1'b0, "R1");
    do_read(A0, 32'h11223344, 1'b0, "R2");
    inj = 32'h0000_0020;
    do_read(A0, 32'h11223344, 1'b0, "R2");
    inj = 32'h0000_0003;
    do_read(A1, 32'h5566778B, 1'b1, "R6");
    inj = '0;

    do_write(A2, 32'hCAFEF00D, 4'b1111, 0, 1'b0, "R1");
    inj = 32'h0001_0000;
    do_read(A2, 32'hCAFFF00D, 1'b0, "R5");
    inj = '0;

    // partial writes with CAS 2 and CAS 3
    do_write(A0, 32'hA1B2C3D4, 4'b0101, 6, 1'b0, "R3");
    do_read(A0, 32'h11B233D4, 1'b0, "R4");
    cl = 2'd3;
    inj = 32'h0000_0100;
    do_write(A1, 32'h99000000, 4'b1000, 7, 1'b0, "R3");
    inj = '0;
    do_read(A1, 32'h99667788, 1'b0, "R4");

    // uncorrectable error in the read phase
    cl = 2'd2;
    inj = 32'h0000_0003;
    do_write(A0, 32'hDEAD0000, 4'b1100, 6, 1'b1, "R7");
    inj = '0;
    do_read(A0, 32'hDEAD33D7, 1'b0, "R7");

    // configuration write lands mid-sequence and must wait
    cl = 2'd3;
    inj = 32'h0000_0200;
    fork
      do_write(A1, 32'h000000EE, 4'b0001, 7, 1'b0, "R9");
      begin
        repeat (2) @(negedge clk);
        cfg_we = 1'b1; cfg_gen = 1'b1; cfg_bank = 4'b0000;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    inj = '0;
    do_read(A1, 32'h996677EE, 1'b0, "R9");
    inj = 32'h0000_0200;
    do_read(A1, 32'h996675EE, 1'b0, "R9");
    inj = '0;

    check(exp_q.size() == 0, "R2", "reads still outstanding", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule